// File: doc/BRIEF.md
# SDRAM Command Bus Protocol Checker

This block is a passive observer for a single-data-rate SDRAM command bus. Every clock it decodes the command on the strobes and keeps its own picture of each internal bank: idle, row open, waiting for an auto-precharge to begin, or precharging. It also keeps a set of spacing timers for rules that span banks, such as activate-to-activate, mode-set recovery and refresh recovery. When a command breaks a timing or state rule, or a row stays open too long, the block latches one error report. The report holds a flag, a 4-bit class code and the bank involved.

All limits are parameters counted in clock cycles, so one netlist can be tuned to the clock rate of the memory controller it sits beside. The report stays put once taken until a synchronous clear input is pulsed. A memory controller bench or an in-system debug path can then read the first violation without losing it to later ones. The checker drives nothing on the bus.

Top module: `sdr_cmd_watch`

## Requirements
- R1: After reset, and on every clock edge where `clr` is high, `err_flag` goes to 0, `err_code` to 0 and `err_bank` to 0. While `err_flag` is 0, code and bank read 0. A violation in the same cycle as `clr` is dropped.
- R2: The first violation appears on the outputs after the clock edge of the violating cycle. Later violations leave flag, code and bank unchanged until `clr`.
- R3: A command is decoded only when `cke` is 1 and `cs_n` is 0. {ras_n,cas_n,we_n} = 000 mode set, 001 refresh, 010 precharge (all banks if `a10`=1, otherwise bank `ba`), 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op. `a10`=1 on a read or write requests auto-precharge. With `cke` low or `cs_n` high the cycle is a no-op.
- R4: Any command other than no-op issued fewer than T_MRD cycles after a mode set gives code 1, with the bank taken from `ba`.
- R5: A refresh while any bank is not idle gives code 2 and the lowest such bank. An activate fewer than T_RFC cycles after a refresh gives code 3.
- R6: An activate to a bank other than the previous activate's bank, fewer than T_RRD cycles after it, gives code 4. Column commands on consecutive cycles raise no error.
- R7: An activate to a bank with an open row, or with an auto-precharge pending, gives code 5. An activate fewer than T_RP cycles after that bank's precharge took effect gives code 6.
- R8: A read or write to a bank without an open row gives code 7. This includes a bank whose auto-precharge is pending.
- R9: A precharge (single or all) that reaches an open bank fewer than BURST_LEN-1+T_WR cycles after a write to it gives code 8 and the lowest such bank. That point is T_WR cycles after the last data beat.
- R10: A row still open T_RAS_MAX+1 cycles after its activate gives code 9 and that bank. A precharge exactly T_RAS_MAX cycles after the activate is legal.
- R11: For a read with auto-precharge, the precharge takes effect BURST_LEN cycles after the command. For a write with auto-precharge, it takes effect BURST_LEN-1+T_WR cycles after the command. The bank then becomes idle T_RP cycles later with no further command.
- R12: When several violations happen in one cycle, the lowest code is reported. Within a code, the lowest bank is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear of the latched report |
| cke | input | 1 | Clock enable seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | clog2(BANKS) | Bank address |
| a10 | input | 1 | Precharge-all / auto-precharge flag |
| err_flag | output | 1 | A violation has been latched |
| err_code | output | 4 | Class of the latched violation (1 to 9) |
| err_bank | output | clog2(BANKS) | Bank of the latched violation |

## Verification
The bench builds the checker with four banks, T_RRD=2, T_MRD=2, T_RFC=9, T_RP=3, T_WR=2 and BURST_LEN=4. It reduces T_RAS_MAX to 20, which puts the open-row limit and its legal boundary within a run of a few dozen cycles instead of thousands. With these values every guard window is a few cycles long. Each rule can then be driven both one cycle inside and exactly at its edge, including the auto-precharge timing for reads and writes. The short windows also allow multi-violation cycles that exercise the priority order.

// File: rtl/sdr_watch_pkg.sv
// Shared types of the SDRAM command bus checker.
// Assumes the command field is {ras_n, cas_n, we_n} as seen on the bus.
package sdr_watch_pkg;

    typedef enum logic [2:0] {
        CMD_MRS = 3'd0,
        CMD_REF = 3'd1,
        CMD_PRE = 3'd2,
        CMD_ACT = 3'd3,
        CMD_WR  = 3'd4,
        CMD_RD  = 3'd5,
        CMD_BST = 3'd6,
        CMD_NOP = 3'd7
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        ERR_NONE     = 4'd0,
        ERR_MRD      = 4'd1,
        ERR_REF_BUSY = 4'd2,
        ERR_RFC      = 4'd3,
        ERR_RRD      = 4'd4,
        ERR_ACT_BUSY = 4'd5,
        ERR_RP       = 4'd6,
        ERR_COL_IDLE = 4'd7,
        ERR_WR_PRE   = 4'd8,
        ERR_RAS_MAX  = 4'd9
    } sdr_err_e;

    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_ACTIVE = 2'd1,
        BK_APWAIT = 2'd2,
        BK_PRECH  = 2'd3
    } bank_st_e;

endpackage

// File: rtl/sdr_cmd_decode.sv
// Turns the raw strobes into one command per cycle.
// Assumes a low clock enable or a high chip select means no command.
module sdr_cmd_decode
    import sdr_watch_pkg::*;
(
    input  logic     cke,
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output sdr_cmd_e cmd
);

    // Map the strobe triple to a command, masking unselected cycles.
    always_comb begin
        if (!cke || cs_n) begin
            cmd = CMD_NOP;
        end else begin
            cmd = sdr_cmd_e'({ras_n, cas_n, we_n});
        end
    end

endmodule

// File: rtl/sdr_bank_track.sv
// Follows one internal bank: open row, pending auto-precharge, precharge
// recovery, write recovery and open-row age.
// Assumes guard counters are loaded with (gap - 1) and block while non-zero.
module sdr_bank_track
    import sdr_watch_pkg::*;
#(
    parameter int T_RP      = 3,
    parameter int T_WR      = 2,
    parameter int BURST_LEN = 4,
    parameter int T_RAS_MAX = 13333
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sel,
    input  sdr_cmd_e cmd,
    input  logic     a10,
    output logic     ready,
    output logic     row_busy,
    output logic     open,
    output logic     wr_block,
    output logic     ras_over
);

    localparam int WR_GAP = BURST_LEN - 1 + T_WR;
    localparam int MAXG   = (WR_GAP > BURST_LEN) ?
                            ((WR_GAP > T_RP) ? WR_GAP : T_RP) :
                            ((BURST_LEN > T_RP) ? BURST_LEN : T_RP);
    localparam int CNT_W  = $clog2(MAXG + 1);
    localparam int AGE_W  = $clog2(T_RAS_MAX + 2);
    localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(T_RAS_MAX + 1);
    localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(T_RAS_MAX);

    bank_st_e         st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] wr_left;
    logic [AGE_W-1:0] age;
    logic             col_hit;
    logic             pre_hit;

    // Which commands reach this bank.
    always_comb begin
        col_hit = sel && ((cmd == CMD_RD) || (cmd == CMD_WR));
        pre_hit = (cmd == CMD_PRE) && (a10 || sel);
    end

    // Status seen by the error logic.
    always_comb begin
        ready    = (st == BK_IDLE) || ((st == BK_PRECH) && (cnt == '0));
        row_busy = (st == BK_ACTIVE) || (st == BK_APWAIT);
        open     = (st == BK_ACTIVE);
        wr_block = (wr_left != '0);
        ras_over = (st == BK_ACTIVE) && (age > AGE_LIM);
    end

    // Bank state, recovery counters and row age.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= BK_IDLE;
            cnt     <= '0;
            wr_left <= '0;
            age     <= '0;
        end else begin
            if (wr_left != '0) begin
                wr_left <= wr_left - 1'b1;
            end
            if ((st == BK_ACTIVE) && (age != AGE_TOP)) begin
                age <= age + 1'b1;
            end
            if (sel && (cmd == CMD_ACT)) begin
                st      <= BK_ACTIVE;
                age     <= AGE_W'(1);
                wr_left <= '0;
            end else if (col_hit && (st == BK_ACTIVE)) begin
                if (cmd == CMD_WR) begin
                    wr_left <= CNT_W'(WR_GAP - 1);
                end
                if (a10) begin
                    st  <= BK_APWAIT;
                    cnt <= (cmd == CMD_WR) ? CNT_W'(WR_GAP - 1)
                                           : CNT_W'(BURST_LEN - 1);
                end
            end else if (pre_hit && (st == BK_ACTIVE)) begin
                st      <= BK_PRECH;
                cnt     <= CNT_W'(T_RP - 1);
                wr_left <= '0;
            end else begin
                case (st)
                    BK_APWAIT: begin
                        if (cnt == '0) begin
                            st  <= BK_PRECH;
                            cnt <= CNT_W'(T_RP - 1);
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    BK_PRECH: begin
                        if (cnt == '0) begin
                            st <= BK_IDLE;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/sdr_bus_spacing.sv
// Timers for rules that span banks: mode-set recovery, refresh recovery
// and activate-to-activate spacing, plus the bank of the last activate.
// Assumes every limit is at least one cycle.
module sdr_bus_spacing
    import sdr_watch_pkg::*;
#(
    parameter int BA_W  = 2,
    parameter int T_RRD = 2,
    parameter int T_MRD = 2,
    parameter int T_RFC = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  sdr_cmd_e        cmd,
    input  logic [BA_W-1:0] ba,
    output logic            mrd_busy,
    output logic            rfc_busy,
    output logic            rrd_busy,
    output logic [BA_W-1:0] last_ba
);

    localparam int MRD_W = $clog2(T_MRD + 1);
    localparam int RFC_W = $clog2(T_RFC + 1);
    localparam int RRD_W = $clog2(T_RRD + 1);

    logic [MRD_W-1:0] mrd_left;
    logic [RFC_W-1:0] rfc_left;
    logic [RRD_W-1:0] rrd_left;

    // Guard windows are open while their counter is non-zero.
    always_comb begin
        mrd_busy = (mrd_left != '0);
        rfc_busy = (rfc_left != '0);
        rrd_busy = (rrd_left != '0);
    end

    // Load each window on its command and count it down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mrd_left <= '0;
            rfc_left <= '0;
            rrd_left <= '0;
            last_ba  <= '0;
        end else begin
            if (cmd == CMD_MRS) begin
                mrd_left <= MRD_W'(T_MRD - 1);
            end else if (mrd_left != '0) begin
                mrd_left <= mrd_left - 1'b1;
            end
            if (cmd == CMD_REF) begin
                rfc_left <= RFC_W'(T_RFC - 1);
            end else if (rfc_left != '0) begin
                rfc_left <= rfc_left - 1'b1;
            end
            if (cmd == CMD_ACT) begin
                rrd_left <= RRD_W'(T_RRD - 1);
                last_ba  <= ba;
            end else if (rrd_left != '0) begin
                rrd_left <= rrd_left - 1'b1;
            end
        end
    end

endmodule

// File: rtl/sdr_err_latch.sv
// Classifies this cycle's violations by fixed priority and keeps the first
// one until cleared.
// Assumes bank status vectors are indexed by bank number.
module sdr_err_latch
    import sdr_watch_pkg::*;
#(
    parameter int NB   = 4,
    parameter int BA_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  sdr_cmd_e        cmd,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    input  logic            mrd_busy,
    input  logic            rfc_busy,
    input  logic            rrd_busy,
    input  logic [BA_W-1:0] last_ba,
    input  logic [NB-1:0]   ready,
    input  logic [NB-1:0]   row_busy,
    input  logic [NB-1:0]   open,
    input  logic [NB-1:0]   wr_block,
    input  logic [NB-1:0]   ras_over,
    output logic            err_flag,
    output logic [3:0]      err_code,
    output logic [BA_W-1:0] err_bank
);

    sdr_err_e        nxt_code;
    logic [BA_W-1:0] nxt_bank;
    logic [NB-1:0]   pre_tgt;
    logic [NB-1:0]   wr_hit;
    logic            is_act;

    // Index of the lowest set bit.
    function automatic logic [BA_W-1:0] low_idx(input logic [NB-1:0] v);
        logic [BA_W-1:0] r;
        r = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (v[i]) r = BA_W'(i);
        end
        return r;
    endfunction

    // Banks reached by a precharge and those still in write recovery.
    always_comb begin
        pre_tgt = '0;
        if (cmd == CMD_PRE) begin
            for (int i = 0; i < NB; i++) begin
                pre_tgt[i] = a10 || (ba == BA_W'(i));
            end
        end
        wr_hit = pre_tgt & open & wr_block;
        is_act = (cmd == CMD_ACT);
    end

    // Pick the highest-priority violation of this cycle.
    always_comb begin
        nxt_code = ERR_NONE;
        nxt_bank = '0;
        if (mrd_busy && (cmd != CMD_NOP)) begin
            nxt_code = ERR_MRD;
            nxt_bank = ba;
        end else if ((cmd == CMD_REF) && !(&ready)) begin
            nxt_code = ERR_REF_BUSY;
            nxt_bank = low_idx(~ready);
        end else if (is_act && rfc_busy) begin
            nxt_code = ERR_RFC;
            nxt_bank = ba;
        end else if (is_act && rrd_busy && (ba != last_ba)) begin
            nxt_code = ERR_RRD;
            nxt_bank = ba;
        end else if (is_act && row_busy[ba]) begin
            nxt_code = ERR_ACT_BUSY;
            nxt_bank = ba;
        end else if (is_act && !ready[ba]) begin
            nxt_code = ERR_RP;
            nxt_bank = ba;
        end else if (((cmd == CMD_RD) || (cmd == CMD_WR)) && !open[ba]) begin
            nxt_code = ERR_COL_IDLE;
            nxt_bank = ba;
        end else if (|wr_hit) begin
            nxt_code = ERR_WR_PRE;
            nxt_bank = low_idx(wr_hit);
        end else if (|ras_over) begin
            nxt_code = ERR_RAS_MAX;
            nxt_bank = low_idx(ras_over);
        end
    end

    // Keep the first report until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            err_flag <= 1'b0;
            err_code <= 4'd0;
            err_bank <= '0;
        end else if (!err_flag && (nxt_code != ERR_NONE)) begin
            err_flag <= 1'b1;
            err_code <= nxt_code;
            err_bank <= nxt_bank;
        end
    end

endmodule

// File: rtl/sdr_cmd_watch.sv
// Top of the SDRAM command bus checker: decodes the bus, tracks every bank
// and the cross-bank timers, and reports the first rule violation.
// Assumes all limits are given in clock cycles and are at least one.
module sdr_cmd_watch
    import sdr_watch_pkg::*;
#(
    parameter int  BANKS     = 4,
    parameter int  T_RRD     = 2,
    parameter int  T_MRD     = 2,
    parameter int  T_RFC     = 9,
    parameter int  T_RP      = 3,
    parameter int  T_WR      = 2,
    parameter int  BURST_LEN = 4,
    parameter int  T_RAS_MAX = 13333,
    localparam int BA_W      = $clog2(BANKS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            cke,
    input  logic            cs_n,
    input  logic            ras_n,
    input  logic            cas_n,
    input  logic            we_n,
    input  logic [BA_W-1:0] ba,
    input  logic            a10,
    output logic            err_flag,
    output logic [3:0]      err_code,
    output logic [BA_W-1:0] err_bank
);

    sdr_cmd_e        cmd;
    logic            mrd_busy;
    logic            rfc_busy;
    logic            rrd_busy;
    logic [BA_W-1:0] last_ba;
    logic [BANKS-1:0] ready;
    logic [BANKS-1:0] row_busy;
    logic [BANKS-1:0] open;
    logic [BANKS-1:0] wr_block;
    logic [BANKS-1:0] ras_over;

    sdr_cmd_decode u_dec (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdr_bus_spacing #(
        .BA_W  (BA_W),
        .T_RRD (T_RRD),
        .T_MRD (T_MRD),
        .T_RFC (T_RFC)
    ) u_space (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .ba       (ba),
        .mrd_busy (mrd_busy),
        .rfc_busy (rfc_busy),
        .rrd_busy (rrd_busy),
        .last_ba  (last_ba)
    );

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        sdr_bank_track #(
            .T_RP      (T_RP),
            .T_WR      (T_WR),
            .BURST_LEN (BURST_LEN),
            .T_RAS_MAX (T_RAS_MAX)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (ba == BA_W'(g)),
            .cmd      (cmd),
            .a10      (a10),
            .ready    (ready[g]),
            .row_busy (row_busy[g]),
            .open     (open[g]),
            .wr_block (wr_block[g]),
            .ras_over (ras_over[g])
        );
    end

    sdr_err_latch #(
        .NB   (BANKS),
        .BA_W (BA_W)
    ) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .cmd      (cmd),
        .ba       (ba),
        .a10      (a10),
        .mrd_busy (mrd_busy),
        .rfc_busy (rfc_busy),
        .rrd_busy (rrd_busy),
        .last_ba  (last_ba),
        .ready    (ready),
        .row_busy (row_busy),
        .open     (open),
        .wr_block (wr_block),
        .ras_over (ras_over),
        .err_flag (err_flag),
        .err_code (err_code),
        .err_bank (err_bank)
    );

endmodule

// File: rtl/sdr_cmd_watch_chk.sv
// Port-level properties of the checker's report, attached by bind.
// Assumes the same reset and clock as the checked block.
module sdr_cmd_watch_chk #(
    parameter int BA_W  = 2,
    parameter int T_MRD = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            clr,
    input logic            cke,
    input logic            cs_n,
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic            err_flag,
    input logic [3:0]      err_code,
    input logic [BA_W-1:0] err_bank
);

    logic mrs_seen;
    logic cmd_live;

    // Bus-level view of a mode set and of any real command.
    always_comb begin
        mrs_seen = cke && !cs_n && ({ras_n, cas_n, we_n} == 3'b000);
        cmd_live = cke && !cs_n && ({ras_n, cas_n, we_n} != 3'b111);
    end

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr) |=> (err_flag && $stable(err_code) && $stable(err_bank)));

    // R1
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!err_flag && err_code == 4'd0));

    // R1
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !err_flag |-> (err_code == 4'd0 && err_bank == '0));

    // R4
    mrd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (T_MRD >= 2 && $past(rst_n) && $past(mrs_seen) && cmd_live && !err_flag && !clr)
        |=> err_flag);

    // R12
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> (err_code >= 4'd1 && err_code <= 4'd9));

endmodule

bind sdr_cmd_watch sdr_cmd_watch_chk #(
    .BA_W  (BA_W),
    .T_MRD (T_MRD)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .err_flag (err_flag),
    .err_code (err_code),
    .err_bank (err_bank)
);

// File: tb/sim_sdr_cmd_watch.sv
// Directed bench for the SDRAM command bus checker.
module sim_sdr_cmd_watch;

    localparam int CLK_PERIOD = 10;
    localparam int NB   = 4;
    localparam int BW   = 2;

    localparam logic [2:0] C_MRS = 3'b000;
    localparam logic [2:0] C_REF = 3'b001;
    localparam logic [2:0] C_PRE = 3'b010;
    localparam logic [2:0] C_ACT = 3'b011;
    localparam logic [2:0] C_WR  = 3'b100;
    localparam logic [2:0] C_RD  = 3'b101;
    localparam logic [2:0] C_NOP = 3'b111;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic cke = 1'b1;
    logic cs_n = 1'b1;
    logic ras_n = 1'b1;
    logic cas_n = 1'b1;
    logic we_n = 1'b1;
    logic [BW-1:0] ba = '0;
    logic a10 = 1'b0;
    logic err_flag;
    logic [3:0] err_code;
    logic [BW-1:0] err_bank;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdr_cmd_watch #(
        .BANKS (NB), .T_RRD (2), .T_MRD (2), .T_RFC (9), .T_RP (3),
        .T_WR (2), .BURST_LEN (4), .T_RAS_MAX (20)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .clr (clr), .cke (cke), .cs_n (cs_n),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .ba (ba), .a10 (a10),
        .err_flag (err_flag), .err_code (err_code), .err_bank (err_bank)
    );

    // One bus cycle with full control of the strobes.
    task automatic drive_raw(input logic k, input logic s, input logic [2:0] c,
                             input int b, input logic ap);
        @(negedge clk);
        clr = 1'b0;
        cke = k;
        cs_n = s;
        {ras_n, cas_n, we_n} = c;
        ba = BW'(b);
        a10 = ap;
    endtask

    task automatic drive(input logic [2:0] c, input int b, input logic ap);
        drive_raw(1'b1, 1'b0, c, b, ap);
    endtask

    task automatic nop(input int n);
        for (int i = 0; i < n; i++) drive(C_NOP, 0, 1'b0);
    endtask

    // Compare the report with the expected one.
    task automatic check(input string req, input int code, input int bank);
        logic ef;
        ef = (code != 0);
        checks++;
        if (err_flag !== ef || err_code !== 4'(code) || err_bank !== BW'(bank)) begin
            errors++;
            $display("FAIL %s: got flag=%0b code=%0d bank=%0d, expected flag=%0b code=%0d bank=%0d",
                     req, err_flag, err_code, err_bank, ef, code, bank);
        end
    endtask

    // Close all rows, let every window lapse and clear the report.
    task automatic settle();
        drive(C_PRE, 0, 1'b1);
        nop(12);
        @(negedge clk);
        clr = 1'b1;
        {ras_n, cas_n, we_n} = C_NOP;
        nop(1);
    endtask

    task automatic t_reset();
        check("R1 reset state", 0, 0);
    endtask

    task automatic t_mrd();
        drive(C_MRS, 0, 1'b0); drive(C_ACT, 0, 1'b0); nop(1);
        check("R4 command right after mode set", 1, 0);
        settle();
        drive(C_MRS, 0, 1'b0); nop(1); drive(C_ACT, 1, 1'b0); nop(1);
        check("R4 command at end of mode-set window", 0, 0);
        settle();
    endtask

    task automatic t_rrd();
        drive(C_ACT, 0, 1'b0); drive(C_ACT, 1, 1'b0); nop(1);
        check("R6 activate spacing too short", 4, 1);
        settle();
        drive(C_ACT, 0, 1'b0); nop(1); drive(C_ACT, 1, 1'b0);
        drive(C_RD, 0, 1'b0); drive(C_RD, 1, 1'b0); drive(C_WR, 0, 1'b0); nop(1);
        check("R6 legal spacing and back-to-back column commands", 0, 0);
        settle();
    endtask

    task automatic t_ref();
        drive(C_ACT, 2, 1'b0); nop(1); drive(C_REF, 0, 1'b0); nop(1);
        check("R5 refresh with an open bank", 2, 2);
        settle();
        drive(C_REF, 0, 1'b0); nop(7); drive(C_ACT, 0, 1'b0); nop(1);
        check("R5 activate inside refresh recovery", 3, 0);
        settle();
        drive(C_REF, 0, 1'b0); nop(8); drive(C_ACT, 0, 1'b0); nop(1);
        check("R5 activate at end of refresh recovery", 0, 0);
        settle();
    endtask

    task automatic t_act();
        drive(C_ACT, 1, 1'b0); nop(2); drive(C_ACT, 1, 1'b0); nop(1);
        check("R7 activate to open bank", 5, 1);
        settle();
        drive(C_ACT, 3, 1'b0); nop(1); drive(C_PRE, 3, 1'b0); nop(1);
        drive(C_ACT, 3, 1'b0); nop(1);
        check("R7 activate during precharge", 6, 3);
        settle();
        drive(C_ACT, 3, 1'b0); nop(1); drive(C_PRE, 3, 1'b0); nop(2);
        drive(C_ACT, 3, 1'b0); nop(1);
        check("R7 activate at end of precharge", 0, 0);
        settle();
    endtask

    task automatic t_col();
        drive(C_RD, 2, 1'b0); nop(1);
        check("R8 read without open row", 7, 2);
        settle();
    endtask

    task automatic t_wr();
        drive(C_ACT, 0, 1'b0); nop(1); drive(C_WR, 0, 1'b0); nop(3);
        drive(C_PRE, 0, 1'b0); nop(1);
        check("R9 precharge inside write recovery", 8, 0);
        settle();
        drive(C_ACT, 0, 1'b0); nop(1); drive(C_WR, 0, 1'b0); nop(4);
        drive(C_PRE, 0, 1'b0); nop(1);
        check("R9 precharge at end of write recovery", 0, 0);
        settle();
        drive(C_ACT, 1, 1'b0); nop(1); drive(C_WR, 1, 1'b0);
        drive(C_PRE, 0, 1'b1); nop(1);
        check("R9 precharge-all during write recovery", 8, 1);
        settle();
    endtask

    task automatic t_ras();
        drive(C_ACT, 2, 1'b0); nop(20); drive(C_NOP, 0, 1'b0);
        check("R10 row at age limit", 0, 0);
        drive(C_NOP, 0, 1'b0);
        check("R10 row past age limit", 9, 2);
        settle();
        drive(C_ACT, 2, 1'b0); nop(19); drive(C_PRE, 2, 1'b0); nop(2);
        check("R10 precharge at age limit", 0, 0);
        settle();
    endtask

    task automatic t_ap();
        drive(C_ACT, 1, 1'b0); nop(1); drive(C_RD, 1, 1'b1); drive(C_ACT, 1, 1'b0); nop(1);
        check("R11 activate with auto-precharge pending", 5, 1);
        settle();
        drive(C_ACT, 1, 1'b0); nop(1); drive(C_RD, 1, 1'b1); drive(C_RD, 1, 1'b0); nop(1);
        check("R8 read with auto-precharge pending", 7, 1);
        settle();
        drive(C_ACT, 1, 1'b0); nop(1); drive(C_RD, 1, 1'b1); nop(5);
        drive(C_ACT, 1, 1'b0); nop(1);
        check("R11 read auto-precharge recovery too short", 6, 1);
        settle();
        drive(C_ACT, 1, 1'b0); nop(1); drive(C_RD, 1, 1'b1); nop(6);
        drive(C_ACT, 1, 1'b0); nop(1);
        check("R11 read auto-precharge done", 0, 0);
        settle();
        drive(C_ACT, 0, 1'b0); nop(1); drive(C_WR, 0, 1'b1); nop(6);
        drive(C_ACT, 0, 1'b0); nop(1);
        check("R11 write auto-precharge recovery too short", 6, 0);
        settle();
    endtask

    task automatic t_sticky();
        drive(C_RD, 0, 1'b0); drive(C_RD, 3, 1'b0); nop(1);
        check("R2 first error kept", 7, 0);
        @(negedge clk);
        clr = 1'b1;
        cs_n = 1'b0;
        {ras_n, cas_n, we_n} = C_WR;
        ba = BW'(2);
        nop(1);
        check("R1 clear wins over same-cycle error", 0, 0);
        settle();
    endtask

    task automatic t_cke();
        drive_raw(1'b0, 1'b0, C_RD, 0, 1'b0);
        drive_raw(1'b1, 1'b1, C_RD, 1, 1'b0);
        nop(1);
        check("R3 masked cycles decode as no-op", 0, 0);
        settle();
    endtask

    task automatic t_prio();
        drive(C_ACT, 2, 1'b0); nop(1); drive(C_MRS, 0, 1'b0); drive(C_REF, 3, 1'b0); nop(1);
        check("R12 lower code wins", 1, 3);
        settle();
        drive(C_ACT, 3, 1'b0); nop(1); drive(C_ACT, 1, 1'b0); nop(1);
        drive(C_REF, 0, 1'b0); nop(1);
        check("R12 lowest bank reported", 2, 1);
        settle();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        nop(1);
        t_reset();
        t_mrd();
        t_rrd();
        t_ref();
        t_act();
        t_col();
        t_wr();
        t_ras();
        t_ap();
        t_sticky();
        t_cke();
        t_prio();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule